// File: doc/BRIEF.md
# In-Network Scalar Reduction Unit

This unit sits inside a switch and performs one collective step for a tree of endpoints. Each operation works on a single 32-bit element. In gathering modes it collects one operand from every enabled child port and one from the local port, in any order. It then folds them together with the selected operator and sends the result on the up port. In modes that return data, the value that arrives from the parent is copied to every enabled child in the cycle it arrives.

There are four modes: barrier, broadcast, reduce and allreduce. The integer operators are bitwise AND, OR and XOR, signed maximum and wrapping sum. There is also one floating-point operator, an IEEE single-precision sum rounded to nearest, ties to even. A new operation is taken only when the unit is idle, so one collective never overlaps the next.

Top module: `innet_reduce`

## Requirements
- R1: After reset, `up_valid` and `dn_valid` are low and `op_ready` is high once the internal reset release has completed.
- R2: `op_start` is accepted only in a cycle where `op_ready` is high, and it latches `op_mode`, `op_func` and `child_en`. While an operation is open, `op_start` has no effect and `op_ready` stays low. `op_ready` returns after the up pulse for reduce, and after the downward copy for the other modes.
- R3: In barrier, reduce and allreduce, `up_valid` rises only after every enabled child and the local port have each presented a valid operand, in any order. Operands on disabled children are ignored.
- R4: Only the first operand a port presents during an operation is used. A repeat on the same port is ignored.
- R5: The bitwise operators are selected by `op_func` codes 0 (AND), 1 (OR) and 2 (XOR).
- R6: Code 3 gives the signed two's-complement maximum. Code 4 gives the sum modulo 2^32.
- R7: Code 5 gives the single-precision floating-point sum, rounded to nearest with ties to even. The fold starts from the local operand and adds children in rising index order. An exact cancellation of nonzero values yields +0.
- R8: Barrier (`op_mode` 0) sends a single up pulse with data zero once all arrivals are in. It then waits for the downward release.
- R9: Broadcast (`op_mode` 1) sends nothing upward. The first `dn_in_valid` drives `dn_valid` equal to the latched child mask, and `dn_data` equal to `dn_in_data`, in that same cycle.
- R10: Reduce (`op_mode` 2) never drives `dn_valid`. Allreduce (`op_mode` 3) sends the fold upward and then copies the downward value to the enabled children in the cycle it arrives.
- R11: `up_valid` is high for exactly one cycle per operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| child_en | input | N_CHILD | Child participation mask, latched at start |
| op_start | input | 1 | Request to open an operation |
| op_mode | input | 2 | 0 barrier, 1 broadcast, 2 reduce, 3 allreduce |
| op_func | input | 3 | Operator code |
| op_ready | output | 1 | Unit idle, start accepted |
| child_valid | input | N_CHILD | Operand strobe per child |
| child_data | input | 32*N_CHILD | Child operands, child k at bits 32k+31..32k |
| local_valid | input | 1 | Local operand strobe |
| local_data | input | 32 | Local operand |
| up_valid | output | 1 | Result pulse toward the parent |
| up_data | output | 32 | Result toward the parent |
| dn_in_valid | input | 1 | Value arriving from the parent |
| dn_in_data | input | 32 | Data arriving from the parent |
| dn_valid | output | N_CHILD | Per-child strobe of the downward copy |
| dn_data | output | 32 | Downward copy data |

## Verification
The bench presents operands out of index order and checks that nothing goes up until the last one has arrived. A unit that counted strobes instead of tracking each port would fire early when a port repeats, or would fold in a disabled port. Repeated and disabled-port operands carry large values, so folding them in gives a visibly wrong sum. The floating-point cases cover a tie that must stay even, a tie that must round up, and an exact cancellation that must give +0; a truncating or wrongly signed adder differs there by one unit in the last place or in the sign bit. A stray downward value in reduce mode, and start requests while busy, are also sent. A unit that leaked these would produce child strobes or switch operator in the middle of an operation.

// File: rtl/innet_reduce_pkg.sv
`timescale 1ns/1ps
package innet_reduce_pkg;
  localparam int WORD_W = 32;
  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    MODE_BARRIER = 2'd0,
    MODE_BCAST   = 2'd1,
    MODE_REDUCE  = 2'd2,
    MODE_ALLRED  = 2'd3
  } mode_e;

  typedef enum logic [2:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_MAX  = 3'd3,
    FN_ISUM = 3'd4,
    FN_FSUM = 3'd5,
    FN_RSV6 = 3'd6,
    FN_RSV7 = 3'd7
  } func_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_GATHER  = 3'd1,
    ST_COMBINE = 3'd2,
    ST_UP      = 3'd3,
    ST_WAIT_DN = 3'd4
  } state_e;
endpackage

// File: rtl/innet_reduce_fadd.sv
`timescale 1ns/1ps
// Single-precision adder, round to nearest even, subnormals kept.
module innet_reduce_fadd
  import innet_reduce_pkg::*;
(
  input  word_t x_i,
  input  word_t y_i,
  output word_t sum_o
);
  localparam int MW = 27;  // 24-bit significand plus guard, round, sticky

  word_t          a, b;
  logic [7:0]     ea, eb, dexp;
  logic [MW-1:0]  ma, mb, mbs, lost;
  logic [MW:0]    s;
  logic [9:0]     e;
  logic [24:0]    r;
  logic           rnd_up, x_nan, y_nan, x_inf, y_inf;

  always_comb begin
    x_nan = (&x_i[30:23]) && (|x_i[22:0]);
    y_nan = (&y_i[30:23]) && (|y_i[22:0]);
    x_inf = (&x_i[30:23]) && !(|x_i[22:0]);
    y_inf = (&y_i[30:23]) && !(|y_i[22:0]);

    // larger magnitude first
    if (x_i[30:0] >= y_i[30:0]) begin
      a = x_i;
      b = y_i;
    end else begin
      a = y_i;
      b = x_i;
    end
    ea   = (a[30:23] == 8'd0) ? 8'd1 : a[30:23];
    eb   = (b[30:23] == 8'd0) ? 8'd1 : b[30:23];
    ma   = {|a[30:23], a[22:0], 3'b000};
    mb   = {|b[30:23], b[22:0], 3'b000};
    dexp = ea - eb;

    // align smaller operand, folding lost bits into sticky
    if (dexp >= 8'd27) begin
      mbs  = '0;
      lost = '1;
    end else begin
      mbs  = mb >> dexp;
      lost = (27'd1 << dexp) - 27'd1;
    end
    mbs[0] = mbs[0] | (|(mb & lost));

    e = {2'b00, ea};
    if (a[31] == b[31]) begin
      s = {1'b0, ma} + {1'b0, mbs};
      if (s[MW]) begin
        s = {1'b0, s[MW:2], s[1] | s[0]};
        e = e + 10'd1;
      end
    end else begin
      s = {1'b0, ma} - {1'b0, mbs};
      for (int i = 0; i < MW; i++) begin
        if (!s[MW-1] && (e > 10'd1)) begin
          s = s << 1;
          e = e - 10'd1;
        end
      end
    end

    rnd_up = s[2] & (s[1] | s[0] | s[3]);
    r      = {1'b0, s[MW-1:3]} + {24'd0, rnd_up};
    if (r[24]) begin
      r = {1'b0, r[24:1]};
      e = e + 10'd1;
    end

    if (x_nan || y_nan || (x_inf && y_inf && (x_i[31] != y_i[31]))) begin
      sum_o = 32'h7FC0_0000;
    end else if (x_inf) begin
      sum_o = x_i;
    end else if (y_inf) begin
      sum_o = y_i;
    end else if (r == 25'd0) begin
      sum_o = {a[31] & b[31], 31'd0};
    end else if (e >= 10'd255) begin
      sum_o = {a[31], 8'hFF, 23'd0};
    end else begin
      sum_o = {a[31], (r[23] ? e[7:0] : 8'd0), r[22:0]};
    end
  end
endmodule

// File: rtl/innet_reduce_alu.sv
`timescale 1ns/1ps
module innet_reduce_alu
  import innet_reduce_pkg::*;
(
  input  func_e func_i,
  input  word_t acc_i,
  input  word_t opd_i,
  output word_t res_o
);
  word_t fsum;

  innet_reduce_fadd u_fadd (
    .x_i   (acc_i),
    .y_i   (opd_i),
    .sum_o (fsum)
  );

  always_comb begin
    case (func_i)
      FN_AND:  res_o = acc_i & opd_i;
      FN_OR:   res_o = acc_i | opd_i;
      FN_XOR:  res_o = acc_i ^ opd_i;
      FN_MAX:  res_o = ($signed(acc_i) >= $signed(opd_i)) ? acc_i : opd_i;
      FN_ISUM: res_o = acc_i + opd_i;
      FN_FSUM: res_o = fsum;
      default: res_o = acc_i;
    endcase
  end
endmodule

// File: rtl/innet_reduce_arrival.sv
`timescale 1ns/1ps
// Per-port arrival flags and operand capture (first value wins).
module innet_reduce_arrival
  import innet_reduce_pkg::*;
#(
  parameter int N_LANE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              open_i,
  input  logic [N_LANE-1:0] lane_en_i,
  input  logic [N_LANE-1:0] lane_vld_i,
  input  word_t             lane_dat_i [N_LANE],
  output word_t             lane_q_o   [N_LANE],
  output logic              all_in_o
);
  logic [N_LANE-1:0] got_q, got_d, take;

  always_comb begin
    got_d = got_q;
    if (clear_i) begin
      got_d = '0;
    end else if (open_i) begin
      got_d = got_q | take;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      got_q <= '0;
    end else begin
      got_q <= got_d;
    end
  end

  for (genvar g = 0; g < N_LANE; g++) begin : g_lane
    assign take[g] = open_i && lane_en_i[g] && lane_vld_i[g] && !got_q[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lane_q_o[g] <= '0;
      end else if (take[g]) begin
        lane_q_o[g] <= lane_dat_i[g];
      end
    end
  end

  assign all_in_o = &(got_q | ~lane_en_i);
endmodule

// File: rtl/innet_reduce_seq.sv
`timescale 1ns/1ps
// Mode sequencing, serial fold over lanes and down-port copy.
module innet_reduce_seq
  import innet_reduce_pkg::*;
#(
  parameter int N_CHILD = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               op_start_i,
  input  mode_e              op_mode_i,
  input  func_e              op_func_i,
  input  logic [N_CHILD-1:0] child_en_i,
  input  logic               all_in_i,
  input  word_t              lane_q_i [N_CHILD+1],
  input  logic               dn_in_valid_i,
  input  word_t              dn_in_data_i,
  output logic               op_ready_o,
  output logic               clear_o,
  output logic               open_o,
  output logic [N_CHILD-1:0] en_o,
  output logic               up_valid_o,
  output word_t              up_data_o,
  output logic [N_CHILD-1:0] dn_valid_o,
  output word_t              dn_data_o
);
  localparam int IW = (N_CHILD > 1) ? $clog2(N_CHILD) : 1;
  localparam logic [IW-1:0] IDX_LAST = IW'(N_CHILD - 1);

  state_e             state_q, state_d;
  mode_e              mode_q;
  func_e              func_q;
  logic [N_CHILD-1:0] en_q;
  logic [IW-1:0]      idx_q, idx_d;
  word_t              acc_q, acc_d, alu_res;
  logic               cfg_ld, idx_ld, acc_ld;

  innet_reduce_alu u_alu (
    .func_i (func_q),
    .acc_i  (acc_q),
    .opd_i  (lane_q_i[idx_q]),
    .res_o  (alu_res)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    acc_d   = acc_q;
    cfg_ld  = 1'b0;
    idx_ld  = 1'b0;
    acc_ld  = 1'b0;
    clear_o = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (op_start_i) begin
          cfg_ld  = 1'b1;
          clear_o = 1'b1;
          state_d = (op_mode_i == MODE_BCAST) ? ST_WAIT_DN : ST_GATHER;
        end
      end
      ST_GATHER: begin
        if (all_in_i) begin
          acc_ld = 1'b1;
          if (mode_q == MODE_BARRIER) begin
            acc_d   = '0;
            state_d = ST_UP;
          end else begin
            acc_d   = lane_q_i[N_CHILD];
            idx_d   = '0;
            idx_ld  = 1'b1;
            state_d = ST_COMBINE;
          end
        end
      end
      ST_COMBINE: begin
        acc_ld = en_q[idx_q];
        acc_d  = alu_res;
        idx_ld = 1'b1;
        idx_d  = idx_q + 1'b1;
        if (idx_q == IDX_LAST) begin
          state_d = ST_UP;
        end
      end
      ST_UP: begin
        state_d = (mode_q == MODE_REDUCE) ? ST_IDLE : ST_WAIT_DN;
      end
      ST_WAIT_DN: begin
        if (dn_in_valid_i) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_BARRIER;
      func_q  <= FN_AND;
      en_q    <= '0;
      idx_q   <= '0;
      acc_q   <= '0;
    end else begin
      state_q <= state_d;
      if (cfg_ld) begin
        mode_q <= op_mode_i;
        func_q <= op_func_i;
        en_q   <= child_en_i;
      end
      if (idx_ld) begin
        idx_q <= idx_d;
      end
      if (acc_ld) begin
        acc_q <= acc_d;
      end
    end
  end

  assign op_ready_o = (state_q == ST_IDLE) && rst_ni;
  assign open_o     = (state_q == ST_GATHER);
  assign en_o       = en_q;
  assign up_valid_o = (state_q == ST_UP);
  assign up_data_o  = acc_q;
  assign dn_valid_o = ((state_q == ST_WAIT_DN) && dn_in_valid_i) ? en_q : '0;
  assign dn_data_o  = dn_in_data_i;
endmodule

// File: rtl/innet_reduce.sv
`timescale 1ns/1ps
module innet_reduce
  import innet_reduce_pkg::*;
#(
  parameter int N_CHILD = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [N_CHILD-1:0]        child_en,
  input  logic                      op_start,
  input  logic [1:0]                op_mode,
  input  logic [2:0]                op_func,
  output logic                      op_ready,
  input  logic [N_CHILD-1:0]        child_valid,
  input  logic [N_CHILD*WORD_W-1:0] child_data,
  input  logic                      local_valid,
  input  logic [WORD_W-1:0]         local_data,
  output logic                      up_valid,
  output logic [WORD_W-1:0]         up_data,
  input  logic                      dn_in_valid,
  input  logic [WORD_W-1:0]         dn_in_data,
  output logic [N_CHILD-1:0]        dn_valid,
  output logic [WORD_W-1:0]         dn_data
);
  localparam int N_LANE = N_CHILD + 1;

  logic [1:0]         rsync_q;
  logic               rst_int_n;
  word_t              lane_dat [N_LANE];
  word_t              lane_q   [N_LANE];
  logic [N_LANE-1:0]  lane_vld;
  logic [N_CHILD-1:0] en_q;
  logic               clear, open, all_in;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsync_q <= 2'b00;
    end else begin
      rsync_q <= {rsync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rsync_q[1];

  for (genvar g = 0; g < N_CHILD; g++) begin : g_unpack
    assign lane_dat[g] = child_data[g*WORD_W +: WORD_W];
  end
  assign lane_dat[N_CHILD] = local_data;
  assign lane_vld          = {local_valid, child_valid};

  innet_reduce_arrival #(.N_LANE(N_LANE)) u_arrival (
    .clk_i      (clk),
    .rst_ni     (rst_int_n),
    .clear_i    (clear),
    .open_i     (open),
    .lane_en_i  ({1'b1, en_q}),
    .lane_vld_i (lane_vld),
    .lane_dat_i (lane_dat),
    .lane_q_o   (lane_q),
    .all_in_o   (all_in)
  );

  innet_reduce_seq #(.N_CHILD(N_CHILD)) u_seq (
    .clk_i         (clk),
    .rst_ni        (rst_int_n),
    .op_start_i    (op_start),
    .op_mode_i     (mode_e'(op_mode)),
    .op_func_i     (func_e'(op_func)),
    .child_en_i    (child_en),
    .all_in_i      (all_in),
    .lane_q_i      (lane_q),
    .dn_in_valid_i (dn_in_valid),
    .dn_in_data_i  (dn_in_data),
    .op_ready_o    (op_ready),
    .clear_o       (clear),
    .open_o        (open),
    .en_o          (en_q),
    .up_valid_o    (up_valid),
    .up_data_o     (up_data),
    .dn_valid_o    (dn_valid),
    .dn_data_o     (dn_data)
  );
endmodule

// File: rtl/innet_reduce_chk.sv
`timescale 1ns/1ps
module innet_reduce_chk #(
  parameter int N_CHILD = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               op_start,
  input logic [1:0]         op_mode,
  input logic [N_CHILD-1:0] child_en,
  input logic               op_ready,
  input logic [N_CHILD-1:0] child_valid,
  input logic               local_valid,
  input logic               up_valid,
  input logic [31:0]        up_data,
  input logic               dn_in_valid,
  input logic [31:0]        dn_in_data,
  input logic [N_CHILD-1:0] dn_valid,
  input logic [31:0]        dn_data
);
  logic [N_CHILD-1:0] mask_q;
  logic [1:0]         mode_q;
  logic [N_CHILD:0]   seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      mode_q <= 2'd0;
      seen_q <= '0;
    end else if (op_start && op_ready) begin
      mask_q <= child_en;
      mode_q <= op_mode;
      seen_q <= '0;
    end else if (!op_ready) begin
      seen_q <= seen_q | {local_valid, child_valid};
    end
  end

  a_r1_quiet_in_reset: assert property (@(posedge clk)
    !rst_n |-> (!up_valid && (dn_valid == '0)));

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && op_ready) |=> !op_ready);

  a_r2_not_ready_on_up: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> !op_ready);

  a_r3_up_after_all: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (&(seen_q | ~{1'b1, mask_q})));

  a_r8_barrier_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (up_valid && (mode_q == 2'd0)) |-> (up_data == 32'd0));

  a_r9_bcast_no_up: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> (mode_q != 2'd1));

  a_r9_dn_within_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_valid) |-> ((dn_valid & ~mask_q) == '0));

  a_r9_dn_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (|dn_valid) |-> (dn_in_valid && (dn_data == dn_in_data)));

  a_r10_reduce_no_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == 2'd2) |-> (dn_valid == '0));

  a_r11_up_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> !up_valid);
endmodule

bind innet_reduce innet_reduce_chk #(.N_CHILD(N_CHILD)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .op_start    (op_start),
  .op_mode     (op_mode),
  .child_en    (child_en),
  .op_ready    (op_ready),
  .child_valid (child_valid),
  .local_valid (local_valid),
  .up_valid    (up_valid),
  .up_data     (up_data),
  .dn_in_valid (dn_in_valid),
  .dn_in_data  (dn_in_data),
  .dn_valid    (dn_valid),
  .dn_data     (dn_data)
);

// File: tb/test_innet_reduce.sv
`timescale 1ns/1ps
module test_innet_reduce;
  localparam int NC = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC-1:0]   child_en = '0;
  logic            op_start = 1'b0;
  logic [1:0]      op_mode = '0;
  logic [2:0]      op_func = '0;
  logic            op_ready;
  logic [NC-1:0]   child_valid = '0;
  logic [NC*32-1:0] child_data = '0;
  logic            local_valid = 1'b0;
  logic [31:0]     local_data = '0;
  logic            up_valid;
  logic [31:0]     up_data;
  logic            dn_in_valid = 1'b0;
  logic [31:0]     dn_in_data = '0;
  logic [NC-1:0]   dn_valid;
  logic [31:0]     dn_data;

  innet_reduce #(.N_CHILD(NC)) i_innet_reduce (.*);

  always #4 clk = ~clk;  // 125 MHz

  logic [31:0]    up_q[$];
  logic [NC+31:0] dn_q[$];
  int n_cmp = 0, n_bad = 0, ups_seen = 0, dns_seen = 0;
  logic [31:0] lv;
  logic [31:0] cv [NC];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: compares outputs against the expected queues
  always @(negedge clk) begin
    if (rst_n) begin
      if (up_valid) begin
        ups_seen++;
        if (up_q.size() == 0) check("R3 R9 unexpected up", {32'd0, up_data}, 64'hFFFF_FFFF_FFFF_FFFF);
        else check("R5 R6 R7 R8 up data", {32'd0, up_data}, {32'd0, up_q.pop_front()});
      end
      if (|dn_valid) begin
        dns_seen++;
        if (dn_q.size() == 0) check("R10 unexpected down", {28'd0, dn_valid, dn_data}, 64'hFFFF_FFFF_FFFF_FFFF);
        else check("R9 R10 down copy", {28'd0, dn_valid, dn_data}, {28'd0, dn_q.pop_front()});
      end
    end
  end

  function automatic logic [31:0] ref_op(input logic [2:0] f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      3'd0: return a & b;
      3'd1: return a | b;
      3'd2: return a ^ b;
      3'd3: return ($signed(a) >= $signed(b)) ? a : b;
      3'd4: return a + b;
      default: return a;
    endcase
  endfunction

  function automatic logic [31:0] ref_fold(input logic [2:0] f, input logic [NC-1:0] en);
    logic [31:0] acc = lv;
    for (int k = 0; k < NC; k++) if (en[k]) acc = ref_op(f, acc, cv[k]);
    return acc;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic start(input logic [1:0] m, input logic [2:0] f, input logic [NC-1:0] en);
    for (int g = 0; g < 1000 && !op_ready; g++) tick();
    op_mode = m; op_func = f; child_en = en; op_start = 1'b1;
    tick();
    op_start = 1'b0;
  endtask

  task automatic put_child(input int k, input logic [31:0] v);
    child_valid[k] = 1'b1;
    child_data[k*32 +: 32] = v;
    tick();
    child_valid[k] = 1'b0;
  endtask

  task automatic put_local(input logic [31:0] v);
    local_valid = 1'b1; local_data = v;
    tick();
    local_valid = 1'b0;
  endtask

  task automatic put_down(input logic [31:0] v);
    dn_in_valid = 1'b1; dn_in_data = v;
    tick();
    dn_in_valid = 1'b0;
  endtask

  // children delivered high index first, local inserted before child lpos
  task automatic gather_all(input int lpos);
    for (int k = NC - 1; k >= 0; k--) begin
      if (k == lpos) put_local(lv);
      put_child(k, cv[k]);
    end
  endtask

  task automatic wait_up();
    for (int g = 0; g < 500 && up_q.size() != 0; g++) tick();
  endtask

  task automatic drain();
    for (int g = 0; g < 500 && (up_q.size() != 0 || dn_q.size() != 0 || !op_ready); g++) tick();
    tick();
  endtask

  task automatic run_red(input logic [2:0] f, input logic [NC-1:0] en, input int lpos);
    up_q.push_back(ref_fold(f, en));
    start(2'd2, f, en);
    gather_all(lpos);
    drain();
  endtask

  task automatic run_fp(input logic [NC-1:0] en, input logic [31:0] exp);
    up_q.push_back(exp);
    start(2'd2, 3'd5, en);
    gather_all(0);
    drain();
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    int ups0;
    repeat (3) tick();
    check("R1 up_valid in reset", {63'd0, up_valid}, 64'd0);
    check("R1 dn_valid in reset", {60'd0, dn_valid}, 64'd0);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 op_ready after reset", {63'd0, op_ready}, 64'd1);

    // R3 R6: sum, arrivals out of order, no early result
    lv = 32'd10; cv = '{32'd1, 32'd2, 32'd3, 32'd4};
    up_q.push_back(32'd20);
    ups0 = ups_seen;
    start(2'd2, 3'd4, 4'b1111);
    put_child(3, cv[3]); put_local(lv); put_child(1, cv[1]);
    repeat (6) tick();
    check("R3 no up before last arrival", ups_seen - ups0, 0);
    check("R2 busy while gathering", {63'd0, op_ready}, 64'd0);
    put_child(0, cv[0]);
    repeat (6) tick();
    check("R3 still no up", ups_seen - ups0, 0);
    put_child(2, cv[2]);
    drain();
    check("R3 R11 one up per op", ups_seen - ups0, 1);

    // R5 bitwise operators
    lv = 32'hF0F0_FFFF; cv = '{32'hFFFF_00FF, 32'hF0FF_FFFF, 32'hFFFF_FFF0, 32'h0FFF_FFFF};
    run_red(3'd0, 4'b1111, 2);
    lv = 32'h0000_0001; cv = '{32'h0000_0100, 32'h0001_0000, 32'h0100_0000, 32'h8000_0000};
    run_red(3'd1, 4'b1111, 0);
    lv = 32'hA5A5_A5A5; cv = '{32'h1234_5678, 32'hFFFF_0000, 32'h0F0F_0F0F, 32'h0000_0001};
    run_red(3'd2, 4'b1111, 3);

    // R6 signed max and wrapping sum
    lv = 32'd5; cv = '{32'hFFFF_FFFD, 32'd7, 32'h8000_0000, 32'd6};
    run_red(3'd3, 4'b1111, 1);
    lv = 32'hFFFF_FFFF; cv = '{32'd1, 32'd1, 32'hFFFF_FFFF, 32'd0};
    run_red(3'd4, 4'b1111, 2);

    // R3 R4 R2: disabled child, repeated child, start while busy
    up_q.push_back(32'd106);
    start(2'd2, 3'd4, 4'b1011);
    put_child(0, 32'd1);
    put_child(0, 32'd50);
    put_local(32'd100);
    op_mode = 2'd1; op_func = 3'd0; op_start = 1'b1;
    tick();
    op_start = 1'b0;
    check("R2 busy ignores start", {63'd0, op_ready}, 64'd0);
    put_child(2, 32'd1000);
    put_child(1, 32'd2);
    put_child(3, 32'd3);
    drain();

    // R10: reduce ignores a downward value
    ups0 = dns_seen;
    put_down(32'h0000_0077);
    repeat (3) tick();
    check("R10 reduce no down copy", dns_seen - ups0, 0);
    check("R10 ready after stray down", {63'd0, op_ready}, 64'd1);

    // R7 floating-point sum
    lv = 32'h3F80_0000; cv = '{32'h4000_0000, 32'h3F00_0000, 32'hBF80_0000, 32'h3E80_0000};
    run_fp(4'b1111, 32'h4030_0000);
    lv = 32'h3F80_0000; cv = '{32'h3380_0000, 32'h4700_0000, 32'h4700_0000, 32'h4700_0000};
    run_fp(4'b0001, 32'h3F80_0000);   // tie stays even
    lv = 32'h3F80_0001;
    run_fp(4'b0001, 32'h3F80_0002);   // tie rounds up to even
    lv = 32'h3F80_0000; cv[0] = 32'hBF80_0000;
    run_fp(4'b0001, 32'h0000_0000);   // cancellation gives +0

    // R8 barrier
    ups0 = ups_seen;
    up_q.push_back(32'd0);
    dn_q.push_back({4'b0110, 32'h0000_005A});
    start(2'd0, 3'd4, 4'b0110);
    put_child(2, 32'h1111_1111);
    put_local(32'h2222_2222);
    repeat (4) tick();
    check("R8 barrier waits for child1", ups_seen - ups0, 0);
    put_child(1, 32'h3333_3333);
    wait_up();
    tick();
    check("R2 barrier busy until release", {63'd0, op_ready}, 64'd0);
    put_down(32'h0000_005A);
    drain();
    check("R8 barrier done", {63'd0, op_ready}, 64'd1);

    // R9 broadcast
    ups0 = ups_seen;
    dn_q.push_back({4'b1101, 32'hDEAD_BEEF});
    start(2'd1, 3'd0, 4'b1101);
    put_local(32'h1);
    tick();
    check("R9 broadcast busy", {63'd0, op_ready}, 64'd0);
    put_down(32'hDEAD_BEEF);
    drain();
    check("R9 broadcast sends nothing up", ups_seen - ups0, 0);

    // R10 allreduce
    lv = 32'h0F0F_0000; cv = '{32'h00FF_00FF, 32'hFFFF_FFFF, 32'h1234_5678, 32'hFFFF_FFFF};
    up_q.push_back(ref_fold(3'd2, 4'b0101));
    dn_q.push_back({4'b0101, 32'h1234_5678});
    start(2'd3, 3'd2, 4'b0101);
    gather_all(1);
    wait_up();
    tick();
    put_down(32'h1234_5678);
    drain();

    check("R2 all expected up seen", up_q.size(), 0);
    check("R9 all expected down seen", dn_q.size(), 0);
    check("R2 idle at end", {63'd0, op_ready}, 64'd1);
    summary();
    $finish;
  end
endmodule